// File: doc/BRIEF.md
# I2C GPIO Expander

This block is an I2C target that gives a bus controller control over a bank of general-purpose pins. It oversamples SCL and SDA on its own system clock, recognises START, repeated START and STOP, and answers only to its own target address. After the address, the controller sends a pointer byte that selects one of three byte-wide registers. It then either writes data bytes into the selected register or, after a repeated START, reads bytes back. The pointer advances by one after every byte.

The pins are presented as three vectors: the pin level coming in, the output value going out and a per-pin output enable. Pointer 0 reads back the synchronised pin levels and cannot be written. Pointer 1 holds the output value. Pointer 2 holds the output enables. SDA is handled as an open-drain line: the block only ever pulls it low or lets it go.

The protocol engine is a state machine with these states:
- `ST_IDLE`: the bus is free.
- `ST_ADDR`: the address bits and the R/W bit are shifted in.
- `ST_ACK_ADDR`: the address acknowledge bit.
- `ST_RX_PTR` and `ST_ACK_PTR`: the pointer byte and its acknowledge.
- `ST_RX_DATA` and `ST_ACK_DATA`: a write byte and its acknowledge.
- `ST_TX_DATA`: a read byte is shifted out.
- `ST_MACK`: the controller's acknowledge is sampled.
- `ST_IGNORE`: the block waits for the next START or STOP.

The transitions are:
- START, from any state: to `ST_ADDR`.
- STOP, from any state: to `ST_IDLE`.
- End of the address bits: `ST_ADDR` to `ST_ACK_ADDR` on a match, `ST_ADDR` to `ST_IGNORE` otherwise.
- End of the address acknowledge: `ST_ACK_ADDR` to `ST_RX_PTR` for a write, or to `ST_TX_DATA` for a read.
- End of a byte: `ST_RX_PTR` to `ST_ACK_PTR`, `ST_RX_DATA` to `ST_ACK_DATA` and `ST_TX_DATA` to `ST_MACK`.
- End of an acknowledge: `ST_ACK_PTR` and `ST_ACK_DATA` both go to `ST_RX_DATA`.
- Controller acknowledge: `ST_MACK` goes to `ST_TX_DATA` on an ACK and to `ST_IGNORE` on a NACK.

Top module: `i2c_gpio_expander`

## Requirements
- R1: A START (SDA falling while SCL is high) followed by ADDR_W address bits that equal TGT_ADDR and an R/W bit of 0 (write) is acknowledged: SDA is held low during the ninth SCL pulse.
- R2: An address that does not match is not acknowledged. The block then ignores every byte until the next START or STOP, so the registers do not change.
- R3: In a write transfer, the first byte after the address loads the pointer. Each further byte is acknowledged and written into the register the pointer selects, and the pointer then increments by one. Pointer 1 is the output value, driven on `gpio_out_o`. Pointer 2 is the output enable, driven on `gpio_oe_o`, where bit value 1 enables that pin's driver.
- R4: A byte written to pointer 0 or to any pointer above 2 is acknowledged and changes no register.
- R5: Reading pointer 0 returns the synchronised level of `gpio_in_i`, MSB first, with bits above GPIO_W read as 0.
- R6: In a read transfer the pointer increments after every byte the controller acknowledges. A NACK from the controller ends the read, and SDA is released before the STOP.
- R7: Reading any pointer above 2 returns 0x00.
- R8: SDA is only pulled low or released, and the block changes it only while SCL is low.
- R9: Reset clears the output value and output enable registers to zero, so every pin starts as an input.
- R10: A repeated START restarts address decoding without a STOP and keeps the pointer, so a pointer written before it selects the register that is read after it.
- R11: A STOP in the middle of a data byte returns the block to idle without writing a register, and the next transfer is handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| gpio_in_i | input | GPIO_W | Pin levels from the pads |
| gpio_out_o | output | GPIO_W | Output value for the pins |
| gpio_oe_o | output | GPIO_W | Per-pin output enable, 1 = drive |

## Verification
The bench targets the following corner cases:
- The pointer wrapping from 0xFF to 0x00. An engine with the wrong pointer width or increment corrupts the following register.
- Writes aimed at the read-only pin register. A design that lets such a write through changes pins it should leave alone.
- A STOP that cuts a byte off halfway. An engine that does not reset its bit counter writes a half-shifted byte or mis-frames the next address.
- A repeated START placed between the pointer write and the read. Clearing the pointer at a START makes the read return the pin register instead of the selected one.
- A burst read that runs past the last register. A design that mishandles the controller's ACK repeats a byte, skips a register or keeps driving SDA after the NACK.

// File: rtl/i2c_gpio_pkg.sv
package i2c_gpio_pkg;

    localparam int BYTE_W = 8;

    // Register pointers decoded by the register file
    localparam logic [BYTE_W-1:0] REG_PINS = 8'h00;
    localparam logic [BYTE_W-1:0] REG_OUT  = 8'h01;
    localparam logic [BYTE_W-1:0] REG_DIR  = 8'h02;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_RX_PTR,
        ST_ACK_PTR,
        ST_RX_DATA,
        ST_ACK_DATA,
        ST_TX_DATA,
        ST_MACK,
        ST_IGNORE
    } tgt_state_e;

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_o      = scl_pipe[STAGES-1];
    assign sda_o      = sda_pipe[STAGES-1];
    assign scl_rise_o = scl_o & ~scl_q;
    assign scl_fall_o = ~scl_o & scl_q;
    assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
    assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import i2c_gpio_pkg::*;
#(
    parameter int GPIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_ptr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] rd_ptr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [GPIO_W-1:0] pins_i,
    output logic [GPIO_W-1:0] out_o,
    output logic [GPIO_W-1:0] oe_o
);

    logic [GPIO_W-1:0] pin_meta;
    logic [GPIO_W-1:0] pin_sync;
    logic [GPIO_W-1:0] out_q;
    logic [GPIO_W-1:0] dir_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_meta <= '0;
            pin_sync <= '0;
        end else begin
            pin_meta <= pins_i;
            pin_sync <= pin_meta;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            dir_q <= '0;
        end else if (wr_en) begin
            case (wr_ptr)
                REG_OUT: out_q <= wr_data[GPIO_W-1:0];
                REG_DIR: dir_q <= wr_data[GPIO_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_ptr)
            REG_PINS: rd_data[GPIO_W-1:0] = pin_sync;
            REG_OUT:  rd_data[GPIO_W-1:0] = out_q;
            REG_DIR:  rd_data[GPIO_W-1:0] = dir_q;
            default:  ;
        endcase
    end

    assign out_o = out_q;
    assign oe_o  = dir_q;

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import i2c_gpio_pkg::*;
#(
    parameter int                ADDR_W   = 7,
    parameter logic [ADDR_W-1:0] TGT_ADDR = 'h24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_level,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] rd_ptr,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_ptr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_oe,
    output tgt_state_e        state_o
);

    localparam int ADDR_BITS = ADDR_W + 1;
    localparam int SR_W      = (ADDR_BITS > BYTE_W) ? ADDR_BITS : BYTE_W;
    localparam int CNT_W     = $clog2(SR_W + 1);
    localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(ADDR_BITS);
    localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(BYTE_W);

    tgt_state_e        state;
    tgt_state_e        state_nx;
    logic [SR_W-1:0]   shift_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] tx_q;
    logic [BYTE_W-1:0] ptr_q;
    logic              rw_q;
    logic              mack_q;
    logic              addr_hit;

    assign addr_hit = (shift_q[ADDR_BITS-1:1] == TGT_ADDR);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = ST_ADDR;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (scl_fall) begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_ADDR:     if (bit_cnt == ADDR_END)
                                 state_nx = addr_hit ? ST_ACK_ADDR : ST_IGNORE;
                ST_ACK_ADDR: state_nx = rw_q ? ST_TX_DATA : ST_RX_PTR;
                ST_RX_PTR:   if (bit_cnt == BYTE_END) state_nx = ST_ACK_PTR;
                ST_ACK_PTR:  state_nx = ST_RX_DATA;
                ST_RX_DATA:  if (bit_cnt == BYTE_END) state_nx = ST_ACK_DATA;
                ST_ACK_DATA: state_nx = ST_RX_DATA;
                ST_TX_DATA:  if (bit_cnt == BYTE_END) state_nx = ST_MACK;
                ST_MACK:     state_nx = mack_q ? ST_TX_DATA : ST_IGNORE;
                ST_IGNORE:   state_nx = ST_IGNORE;
            endcase
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            bit_cnt <= '0;
            tx_q    <= '0;
            ptr_q   <= '0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_ptr  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det || stop_det) begin
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (scl_rise) begin
                case (state)
                    ST_ADDR, ST_RX_PTR, ST_RX_DATA: begin
                        shift_q <= {shift_q[SR_W-2:0], sda_level};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    ST_TX_DATA: bit_cnt <= bit_cnt + 1'b1;
                    ST_MACK: begin
                        mack_q <= ~sda_level;
                        if (!sda_level) ptr_q <= ptr_q + 1'b1;
                    end
                    default: ;
                endcase
            end else if (scl_fall) begin
                case (state)
                    ST_ADDR: if (bit_cnt == ADDR_END) begin
                        rw_q   <= shift_q[0];
                        sda_oe <= addr_hit;
                    end
                    ST_ACK_ADDR: begin
                        bit_cnt <= '0;
                        if (rw_q) begin
                            tx_q   <= rd_data[BYTE_W-2:0];
                            sda_oe <= ~rd_data[BYTE_W-1];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                    ST_RX_PTR: if (bit_cnt == BYTE_END) begin
                        ptr_q  <= shift_q[BYTE_W-1:0];
                        sda_oe <= 1'b1;
                    end
                    ST_ACK_PTR, ST_ACK_DATA: begin
                        bit_cnt <= '0;
                        sda_oe  <= 1'b0;
                    end
                    ST_RX_DATA: if (bit_cnt == BYTE_END) begin
                        wr_en   <= 1'b1;
                        wr_ptr  <= ptr_q;
                        wr_data <= shift_q[BYTE_W-1:0];
                        ptr_q   <= ptr_q + 1'b1;
                        sda_oe  <= 1'b1;
                    end
                    ST_TX_DATA: begin
                        if (bit_cnt == BYTE_END) begin
                            sda_oe <= 1'b0;
                        end else begin
                            sda_oe <= ~tx_q[BYTE_W-2];
                            tx_q   <= {tx_q[BYTE_W-3:0], 1'b0};
                        end
                    end
                    ST_MACK: begin
                        if (mack_q) begin
                            bit_cnt <= '0;
                            tx_q    <= rd_data[BYTE_W-2:0];
                            sda_oe  <= ~rd_data[BYTE_W-1];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end

    assign rd_ptr  = ptr_q;
    assign state_o = state;

endmodule

// File: rtl/i2c_gpio_expander.sv
module i2c_gpio_expander
    import i2c_gpio_pkg::*;
#(
    parameter int                GPIO_W   = 8,
    parameter int                ADDR_W   = 7,
    parameter logic [ADDR_W-1:0] TGT_ADDR = 'h24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [GPIO_W-1:0] gpio_in_i,
    output logic [GPIO_W-1:0] gpio_out_o,
    output logic [GPIO_W-1:0] gpio_oe_o
);

    logic              scl_sy;
    logic              sda_sy;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic [BYTE_W-1:0] rd_ptr;
    logic [BYTE_W-1:0] rd_data;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_ptr;
    logic [BYTE_W-1:0] wr_data;
    tgt_state_e        fsm_state;

    i2c_bus_sync #(.STAGES(2)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_sy),
        .sda_o      (sda_sy),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2c_target_fsm #(.ADDR_W(ADDR_W), .TGT_ADDR(TGT_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_level (sda_sy),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .rd_ptr    (rd_ptr),
        .wr_en     (wr_en),
        .wr_ptr    (wr_ptr),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe_o),
        .state_o   (fsm_state)
    );

    gpio_regfile #(.GPIO_W(GPIO_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .wr_data (wr_data),
        .rd_ptr  (rd_ptr),
        .rd_data (rd_data),
        .pins_i  (gpio_in_i),
        .out_o   (gpio_out_o),
        .oe_o    (gpio_oe_o)
    );

endmodule

// File: rtl/i2c_gpio_checker.sv
module i2c_gpio_checker
    import i2c_gpio_pkg::*;
#(
    parameter int GPIO_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_sy,
    input logic              start_det,
    input logic              sda_oe_o,
    input logic              wr_en,
    input logic [BYTE_W-1:0] wr_ptr,
    input logic [BYTE_W-1:0] rd_ptr,
    input logic [GPIO_W-1:0] gpio_out_o,
    input logic [GPIO_W-1:0] gpio_oe_o,
    input tgt_state_e        fsm_state
);

    // R8: SDA is only pulled low while SCL is low
    p_pull_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_sy);

    // R8: SDA is released whenever the engine is idle or ignoring the bus
    p_release_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE || fsm_state == ST_IGNORE) |-> !sda_oe_o);

    // R9: while reset is held, every pin stays an input with output value 0
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (gpio_oe_o == '0) && (gpio_out_o == '0));

    // R3: the registers change only after a write strobe
    p_hold_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(gpio_out_o) && $stable(gpio_oe_o));

    // R3: the pointer has moved one past the written register
    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> rd_ptr == wr_ptr + 8'd1);

    // R4: writes to the pin register or unmapped pointers change nothing
    p_ro_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ptr != REG_OUT && wr_ptr != REG_DIR)
        |=> $stable(gpio_out_o) && $stable(gpio_oe_o));

    // R10: a START always restarts address decoding
    p_start_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> fsm_state == ST_ADDR);

endmodule

bind i2c_gpio_expander i2c_gpio_checker #(.GPIO_W(GPIO_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_sy     (scl_sy),
    .start_det  (start_det),
    .sda_oe_o   (sda_oe_o),
    .wr_en      (wr_en),
    .wr_ptr     (wr_ptr),
    .rd_ptr     (rd_ptr),
    .gpio_out_o (gpio_out_o),
    .gpio_oe_o  (gpio_oe_o),
    .fsm_state  (fsm_state)
);

// File: tb/i2c_gpio_expander_bench.sv
module i2c_gpio_expander_bench;

    localparam int         Q       = 20;
    localparam logic [7:0] ADDR_WR = 8'h48;
    localparam logic [7:0] ADDR_RD = 8'h49;
    localparam logic [7:0] ADDR_NO = 8'h4A;
    localparam int         NVEC    = 7;
    // {pointer, write data, expected readback}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h01, 8'h5A, 8'h5A},
        {8'h02, 8'hC3, 8'hC3},
        {8'h00, 8'hFF, 8'h3C},
        {8'h05, 8'h11, 8'h00},
        {8'hFF, 8'h22, 8'h00},
        {8'h01, 8'h96, 8'h96},
        {8'h02, 8'h0F, 8'h0F}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic       sda_oe;
    logic       sda_line;
    logic [7:0] pins = 8'h3C;
    logic [7:0] gpio_out;
    logic [7:0] gpio_oe;
    int         n_cmp = 0;
    int         n_bad = 0;
    int         oe_glitch = 0;
    logic       prev_oe = 1'b0;
    logic       done = 1'b0;

    always #5 clk = ~clk;

    assign sda_line = ~(m_low | sda_oe);

    i2c_gpio_expander u_i2c_gpio_expander (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_oe_o   (sda_oe),
        .gpio_in_i  (pins),
        .gpio_out_o (gpio_out),
        .gpio_oe_o  (gpio_oe)
    );

    // R8 monitor: the pull-down must not change while SCL is high
    always @(negedge clk) begin
        if (rst_n && sda_oe !== prev_oe && scl) oe_glitch++;
        prev_oe <= sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
    endtask

    task automatic bus_rstart();
        m_low = 1'b0; wq(Q); scl = 1'b1; wq(2*Q);
        m_low = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wq(Q); scl = 1'b1; wq(2*Q); m_low = 1'b0; wq(2*Q);
    endtask

    task automatic put_bit(input logic b);
        m_low = ~b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
    endtask

    task automatic get_bit(output logic b);
        m_low = 1'b0; wq(Q); scl = 1'b1; wq(Q); b = sda_line; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic put_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic get_byte(output logic [7:0] d, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(~give_ack);
    endtask

    task automatic reg_write(input logic [7:0] p, input logic [7:0] d);
        logic a;
        bus_start();
        put_byte(ADDR_WR, a); chk("R1 address ack", a, 1'b1);
        put_byte(p, a);       chk("R3 pointer ack", a, 1'b1);
        put_byte(d, a);       chk("R4 data ack", a, 1'b1);
        bus_stop();
    endtask

    task automatic reg_read(input logic [7:0] p, output logic [7:0] d);
        logic a;
        bus_start();
        put_byte(ADDR_WR, a);
        put_byte(p, a);
        bus_rstart();
        put_byte(ADDR_RD, a); chk("R10 read address ack", a, 1'b1);
        get_byte(d, 1'b0);
        bus_stop();
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_sim();
    end

    initial begin
        logic [7:0] rd;
        logic       a;
        wq(5);
        chk("R9 reset out", gpio_out, 8'h00);
        chk("R9 reset oe", gpio_oe, 8'h00);
        chk("R8 reset sda", sda_oe, 1'b0);
        rst_n = 1'b1;
        wq(10);

        // Vector table: write then read back each register
        for (int i = 0; i < NVEC; i++) begin
            reg_write(VEC[i][23:16], VEC[i][15:8]);
            reg_read(VEC[i][23:16], rd);
            if (VEC[i][23:16] == 8'h01 || VEC[i][23:16] == 8'h02)
                chk("R3 readback", rd, VEC[i][7:0]);
            else if (VEC[i][23:16] == 8'h00)
                chk("R4 R5 pin register", rd, VEC[i][7:0]);
            else
                chk("R7 unmapped read", rd, VEC[i][7:0]);
        end
        chk("R3 out port", gpio_out, 8'h96);
        chk("R3 oe port", gpio_oe, 8'h0F);

        // R3: auto-increment across two data bytes
        bus_start();
        put_byte(ADDR_WR, a);
        put_byte(8'h01, a);
        put_byte(8'h11, a); chk("R3 first data ack", a, 1'b1);
        put_byte(8'h22, a); chk("R3 second data ack", a, 1'b1);
        bus_stop();
        wq(4);
        chk("R3 incr out", gpio_out, 8'h11);
        chk("R3 incr oe", gpio_oe, 8'h22);

        // R6 R7: burst read through the map and past its end
        bus_start();
        put_byte(ADDR_WR, a);
        put_byte(8'h00, a);
        bus_rstart();
        put_byte(ADDR_RD, a);
        get_byte(rd, 1'b1); chk("R6 burst byte0", rd, 8'h3C);
        get_byte(rd, 1'b1); chk("R6 burst byte1", rd, 8'h11);
        get_byte(rd, 1'b1); chk("R6 burst byte2", rd, 8'h22);
        get_byte(rd, 1'b0); chk("R7 burst byte3", rd, 8'h00);
        chk("R6 released after nack", sda_oe, 1'b0);
        bus_stop();

        // R2: foreign address, bytes that follow must be ignored
        bus_start();
        put_byte(ADDR_NO, a); chk("R2 no ack", a, 1'b0);
        put_byte(8'h01, a);
        put_byte(8'hFF, a);
        bus_stop();
        wq(4);
        chk("R2 out unchanged", gpio_out, 8'h11);

        // R11: STOP in the middle of a data byte
        bus_start();
        put_byte(ADDR_WR, a);
        put_byte(8'h01, a);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_stop();
        wq(4);
        chk("R11 out unchanged", gpio_out, 8'h11);
        reg_write(8'h02, 8'h5C);
        chk("R11 next transfer", gpio_oe, 8'h5C);

        // R10: pointer survives a repeated START
        bus_start();
        put_byte(ADDR_WR, a);
        put_byte(8'h02, a);
        bus_rstart();
        put_byte(ADDR_RD, a);
        get_byte(rd, 1'b0);
        bus_stop();
        chk("R10 pointer kept", rd, 8'h5C);

        // R5: pin level change is seen on read
        pins = 8'hA1;
        wq(5);
        reg_read(8'h00, rd);
        chk("R5 pin level", rd, 8'hA1);

        chk("R8 sda stable while SCL high", oe_glitch, 0);

        // R9: reset in the middle of operation
        rst_n = 1'b0;
        wq(5);
        chk("R9 mid reset out", gpio_out, 8'h00);
        chk("R9 mid reset oe", gpio_oe, 8'h00);
        rst_n = 1'b1;
        wq(5);

        finish_sim();
    end

endmodule